// File: doc/BRIEF.md
# Sticky Interrupt Status Aggregator

This block gathers event lines from a hardware monitor (fan speed faults, limit violations and the like) into a set of sticky interrupt status registers and drives one active-low, open-drain interrupt pin. Each event source has its own status bit and its own enable bit. The status bits are grouped into equal-width registers. Each register has its own read strobe.

A status bit latches whenever its event line is high. A read of its register only attempts to clear the bit. If the event is still present, the bit stays set. The pin pulls low while at least one enabled status bit is set, but only if all of the following hold: the global interrupt enable is on, the monitor is in its monitoring state, and the pin has not been silenced by an answered alert-response call. After such a silencing, the pin stays released until one of two things happens: an enabled event line rises again, or software turns the global enable off and back on. Software is expected to clear the global enable before reading the status registers, and to set it again afterwards, so that an event that is still active pulls the pin again.

Top module: `isa_irq_aggregator`

## Requirements
- R1: During and after synchronous active-low reset, every status bit reads 0, the pin is released (`irq_pull_low_o` = 0) and no alert-response silencing is in effect.
- R2: A status bit is set after every clock edge at which its event line is high. It stays set until a read of its register clears it.
- R3: A read strobe clears the bits of its register whose event line is low in that cycle. Bits whose event line is high in the same cycle stay set, because setting wins over clearing.
- R4: A read strobe for one register leaves the status bits of every other register unchanged.
- R5: `irq_pull_low_o` is a registered open-drain enable, where 1 means pull the pin low. After each edge, it equals the AND of four terms, all taken as they were before that edge: at least one status bit that is both set and enabled, the global enable, the monitoring flag, and no silencing.
- R6: A status bit whose enable is 0 still records its event. However, on its own it never pulls the pin.
- R7: While the global enable is 0, the pin is released. Setting the global enable from 0 to 1 removes any silencing, so the pin pulls again while an enabled set bit remains.
- R8: An alert-response pulse silences the pin from the next edge on. The silencing ends at the first edge where an enabled event line goes from 0 to 1. If that rising edge and the pulse arrive in the same cycle, the rising edge wins.
- R9: While the monitoring flag is 0, the pin is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stim_i | input | NUM_REGS*REG_W | Event lines, one per status bit; register r owns bits [r*REG_W +: REG_W] |
| src_en_i | input | NUM_REGS*REG_W | Per-bit interrupt enables, laid out the same way as `stim_i` |
| glob_en_i | input | 1 | Global interrupt enable |
| rd_strobe_i | input | NUM_REGS | One read strobe per status register |
| ara_done_i | input | 1 | One-cycle pulse: an alert-response call has been answered |
| mon_run_i | input | 1 | Monitor block is in its monitoring state |
| status_o | output | NUM_REGS*REG_W | Current contents of all status registers (read data) |
| irq_pull_low_o | output | 1 | Open-drain enable; 1 means pull the interrupt pin low |

## Verification
The bench builds the block with NUM_REGS=2 and REG_W=4, which gives eight sources in two registers. With that size, every source can be pulsed on its own, reads can be tested across both registers, and the pin can be swept over all 16 enable patterns against all 16 status patterns of one register. A cycle-accurate model derived from the requirements runs alongside the design. It also follows a long pseudo-random phase that mixes event lines, reads, enables, alert-response pulses and monitoring changes, so that collisions such as set-versus-clear and pulse-versus-edge come up many times.

// File: rtl/isa_pkg.sv
// Package: shared types for the sticky interrupt status aggregator.
// Assumes nothing beyond the standard; holds the silencing state encoding.
package isa_pkg;
    typedef enum logic {
        SIL_OFF = 1'b0,
        SIL_ON  = 1'b1
    } sil_state_t;
endpackage

// File: rtl/isa_status_reg.sv
// Module: one sticky status register.
// Each bit is set by its event line and cleared by a read strobe only when
// its event line is low in the same cycle (setting wins).
// Assumes rd_i is a one-cycle strobe synchronous to clk.
module isa_status_reg #(
    parameter int REG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] stim_i,
    input  logic             rd_i,
    output logic [REG_W-1:0] stat_o
);
    logic [REG_W-1:0] stat_q;
    logic [REG_W-1:0] stat_d;

    // Next state: set from event lines, keep unless a read attempts a clear.
    always_comb begin
        stat_d = stim_i | (stat_q & {REG_W{~rd_i}});
    end

    // Status storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat_o = stat_q;

    // R2: every bit with a high event line is set after the edge.
    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past(stim_i)) == $past(stim_i)));
    // R3: a read clears every bit whose event line was low.
    a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> ((stat_q & ~$past(stim_i)) == '0));
    // R4: without a read of this register no bit falls.
    a_r4_no_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

// File: rtl/isa_silence.sv
// Module: alert-response silencing tracker.
// An answered alert-response call silences the pin. An enabled event line
// rising, or the global enable rising, ends the silencing; these win over a
// simultaneous alert-response pulse.
// Assumes ara_i is a one-cycle pulse.
module isa_silence #(
    parameter int TOT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TOT_W-1:0] stim_i,
    input  logic [TOT_W-1:0] en_i,
    input  logic             glob_en_i,
    input  logic             ara_i,
    output logic             silenced_o
);
    import isa_pkg::*;

    sil_state_t       sil_q;
    sil_state_t       sil_d;
    logic [TOT_W-1:0] stim_q;
    logic             glob_q;
    logic             new_edge;
    logic             glob_rise;

    // Detect a fresh enabled event edge and a global enable rise.
    always_comb begin
        new_edge  = |(stim_i & ~stim_q & en_i);
        glob_rise = glob_en_i & ~glob_q;
        if (new_edge || glob_rise) sil_d = SIL_OFF;
        else if (ara_i)            sil_d = SIL_ON;
        else                       sil_d = sil_q;
    end

    // State and edge-history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sil_q  <= SIL_OFF;
            stim_q <= '0;
            glob_q <= 1'b0;
        end else begin
            sil_q  <= sil_d;
            stim_q <= stim_i;
            glob_q <= glob_en_i;
        end
    end

    assign silenced_o = (sil_q == SIL_ON);

    // R8: a pulse with no competing edge leaves the pin silenced.
    a_r8_ara_silences: assert property (@(posedge clk) disable iff (!rst_n)
        (ara_i && !(|(stim_i & ~stim_q & en_i)) && !(glob_en_i && !glob_q))
        |=> silenced_o);
    // R8: a new enabled event edge always lifts the silencing.
    a_r8_edge_unsilences: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stim_i & ~stim_q & en_i)) |=> !silenced_o);
endmodule

// File: rtl/isa_pin_drive.sv
// Module: registered open-drain pin enable.
// Pulls low when an enabled status bit is set and all gates allow it.
// Assumes all inputs are synchronous to clk.
module isa_pin_drive #(
    parameter int TOT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TOT_W-1:0] stat_i,
    input  logic [TOT_W-1:0] en_i,
    input  logic             glob_en_i,
    input  logic             mon_run_i,
    input  logic             silenced_i,
    output logic             pull_o
);
    logic pull_d;
    logic pull_q;

    // Combine pending enabled bits with the global, monitor and silence gates.
    always_comb begin
        pull_d = (|(stat_i & en_i)) & glob_en_i & mon_run_i & ~silenced_i;
    end

    // Register the pin enable so the pad sees a glitch-free level.
    always_ff @(posedge clk) begin
        if (!rst_n) pull_q <= 1'b0;
        else        pull_q <= pull_d;
    end

    assign pull_o = pull_q;

    // R7: a cleared global enable releases the pin.
    a_r7_glob_gates: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en_i |=> !pull_o);
    // R9: leaving the monitoring state releases the pin.
    a_r9_mon_gates: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_run_i |=> !pull_o);
    // R6: with no enabled bit set, the pin is released.
    a_r6_nothing_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_i & en_i) == '0) |=> !pull_o);
endmodule

// File: rtl/isa_irq_aggregator.sv
// Module: top of the sticky interrupt status aggregator.
// Builds NUM_REGS sticky status registers of REG_W bits each, an
// alert-response silencing tracker and the registered pin driver.
// Assumes synchronous active-low reset and single-cycle read strobes.
module isa_irq_aggregator #(
    parameter int NUM_REGS = 2,
    parameter int REG_W    = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_REGS*REG_W-1:0]   stim_i,
    input  logic [NUM_REGS*REG_W-1:0]   src_en_i,
    input  logic                        glob_en_i,
    input  logic [NUM_REGS-1:0]         rd_strobe_i,
    input  logic                        ara_done_i,
    input  logic                        mon_run_i,
    output logic [NUM_REGS*REG_W-1:0]   status_o,
    output logic                        irq_pull_low_o
);
    localparam int TOT_W = NUM_REGS * REG_W;

    logic [TOT_W-1:0] stat_all;
    logic             silenced;

    // One sticky register per status group.
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        isa_status_reg #(.REG_W(REG_W)) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .stim_i (stim_i[r*REG_W +: REG_W]),
            .rd_i   (rd_strobe_i[r]),
            .stat_o (stat_all[r*REG_W +: REG_W])
        );
    end

    isa_silence #(.TOT_W(TOT_W)) u_sil (
        .clk        (clk),
        .rst_n      (rst_n),
        .stim_i     (stim_i),
        .en_i       (src_en_i),
        .glob_en_i  (glob_en_i),
        .ara_i      (ara_done_i),
        .silenced_o (silenced)
    );

    isa_pin_drive #(.TOT_W(TOT_W)) u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_i     (stat_all),
        .en_i       (src_en_i),
        .glob_en_i  (glob_en_i),
        .mon_run_i  (mon_run_i),
        .silenced_i (silenced),
        .pull_o     (irq_pull_low_o)
    );

    assign status_o = stat_all;

    // R1: while reset is held, the pin is released after each edge.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !irq_pull_low_o);
endmodule

// File: tb/tb_isa_irq_aggregator.sv
// Bench: drives inputs on the falling edge, advances a requirement-derived
// model on the rising edge and compares on the next falling edge.
module tb_isa_irq_aggregator;
    localparam int NR = 2;
    localparam int RW = 4;
    localparam int TW = NR * RW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] stim = '0;
    logic [TW-1:0] en = '0;
    logic          glob = 1'b0;
    logic [NR-1:0] rd = '0;
    logic          ara = 1'b0;
    logic          mon = 1'b0;
    logic [TW-1:0] status;
    logic          pull;

    int errors = 0;
    int checks = 0;
    string tag = "R1";

    // expected state
    logic [TW-1:0] m_stat = '0;
    logic [TW-1:0] m_stimq = '0;
    logic          m_globq = 1'b0;
    logic          m_sil = 1'b0;
    logic          m_pull = 1'b0;

    always #2 clk = ~clk;

    isa_irq_aggregator #(.NUM_REGS(NR), .REG_W(RW)) dut (
        .clk(clk), .rst_n(rst_n), .stim_i(stim), .src_en_i(en),
        .glob_en_i(glob), .rd_strobe_i(rd), .ara_done_i(ara),
        .mon_run_i(mon), .status_o(status), .irq_pull_low_o(pull)
    );

    task automatic check(input string req, input logic [TW-1:0] act,
                         input logic [TW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: model advances at the rising edge, outputs compared after.
    task automatic step();
        logic [TW-1:0] rdm;
        logic          edge_seen;
        @(posedge clk);
        rdm = '0;
        for (int r = 0; r < NR; r++) if (rd[r]) rdm[r*RW +: RW] = '1;
        if (!rst_n) begin
            m_stat = '0; m_stimq = '0; m_globq = 1'b0; m_sil = 1'b0; m_pull = 1'b0;
        end else begin
            m_pull = (|(m_stat & en)) & glob & mon & ~m_sil;
            edge_seen = |(stim & ~m_stimq & en);
            if (edge_seen || (glob && !m_globq)) m_sil = 1'b0;
            else if (ara)                        m_sil = 1'b1;
            m_stat  = stim | (m_stat & ~rdm);
            m_stimq = stim;
            m_globq = glob;
        end
        @(negedge clk);
        check(tag, status, m_stat);
        check(tag, {{(TW-1){1'b0}}, pull}, {{(TW-1){1'b0}}, m_pull});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        @(negedge clk);
        // R1: reset state, with events active during reset
        tag = "R1";
        stim = '1; en = '1; glob = 1'b1; mon = 1'b1;
        idle(3);
        stim = '0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", status, '0);
        check("R1", {{(TW-1){1'b0}}, pull}, '0);

        // R2: each source alone, one-cycle pulse, bit stays set
        tag = "R2";
        en = '0;
        for (int b = 0; b < TW; b++) begin
            stim = '0; stim[b] = 1'b1;
            step();
            stim = '0;
            idle(2);
            check("R2", status, TW'(1) << b);
            rd = '1; step(); rd = '0;
            check("R2", status, '0);
        end

        // R3: read with event held keeps bit; with event low clears
        tag = "R3";
        stim = 8'h5A; step();
        stim = 8'h50; rd = '1; step(); rd = '0;
        check("R3", status, 8'h50);
        stim = '0; rd = '1; step(); rd = '0;
        check("R3", status, '0);

        // R4: a read of one register leaves the other intact
        tag = "R4";
        stim = 8'hFF; step(); stim = '0;
        rd = 2'b01; step(); rd = '0;
        check("R4", status, 8'hF0);
        stim = 8'hFF; step(); stim = '0;
        rd = 2'b10; step(); rd = '0;
        check("R4", status, 8'h0F);
        rd = '1; step(); rd = '0;

        // R5/R6: all enable patterns against all status patterns of reg 0
        tag = "R6";
        glob = 1'b1; mon = 1'b1;
        for (int e = 0; e < 16; e++) begin
            for (int s = 0; s < 16; s++) begin
                en = TW'(e);
                stim = TW'(s); step(); stim = '0;
                idle(1);
                check("R5", {{(TW-1){1'b0}}, pull},
                      {{(TW-1){1'b0}}, ((e & s) != 0)});
                rd = '1; step(); rd = '0;
            end
        end

        // R7: global enable gates the pin; re-enable re-asserts
        tag = "R7";
        en = '1; glob = 1'b0;
        stim = 8'h01;
        idle(3);
        check("R7", {{(TW-1){1'b0}}, pull}, '0);
        rd = 2'b01; step(); rd = '0;
        check("R7", status, 8'h01);
        glob = 1'b1; idle(1);
        check("R7", {{(TW-1){1'b0}}, pull}, 8'h01);

        // R8: alert-response silences, re-enable and new edge lift it
        tag = "R8";
        ara = 1'b1; step(); ara = 1'b0;
        idle(2);
        check("R8", {{(TW-1){1'b0}}, pull}, '0);
        stim = 8'h03; idle(2);
        check("R8", {{(TW-1){1'b0}}, pull}, 8'h01);
        ara = 1'b1; step(); ara = 1'b0; idle(1);
        glob = 1'b0; step(); glob = 1'b1; idle(2);
        check("R8", {{(TW-1){1'b0}}, pull}, 8'h01);
        stim = 8'h03; ara = 1'b1; step(); stim = 8'h07; step(); ara = 1'b0;
        idle(2);
        check("R8", {{(TW-1){1'b0}}, pull}, 8'h01);

        // R9: leaving monitoring releases the pin
        tag = "R9";
        mon = 1'b0; idle(2);
        check("R9", {{(TW-1){1'b0}}, pull}, '0);
        mon = 1'b1; idle(2);
        stim = '0; rd = '1; step(); rd = '0;

        // R5: long pseudo-random mix against the model
        tag = "R5";
        lfsr = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            stim = lfsr[7:0] & lfsr[15:8] & {TW{lfsr[3]}};
            if (lfsr[11:9] == 3'd0) en = lfsr[15:8];
            rd   = (lfsr[5:4] == 2'b11) ? lfsr[1:0] : 2'b00;
            ara  = (lfsr[14:12] == 3'b101);
            glob = (lfsr[6:2] != 5'd0);
            mon  = (lfsr[13:9] != 5'd31);
            step();
        end
        stim = '0; rd = '0; ara = 1'b0;
        idle(2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule